// File: doc/BRIEF.md
# Zero-Overhead Nested Loop Controller

This block takes loop bookkeeping out of a micro-programmed sequencer. When the sequencer issues a loop instruction it pulses `loop_start` and presents the last body address and an iteration count. In that cycle `pc` already holds the address of the instruction after the loop instruction, so that value becomes the loop's start address. From then on the block compares `pc` against the active loop's end address on every cycle.

When the end instruction is reached, the block does one of two things. It either asks the sequencer to fetch the loop start next (`branch_back` with `branch_addr`), or it marks the loop finished (`loop_done`). In the second case the sequencer falls through to the next sequential address and control passes back to the enclosing loop. The outputs are combinational from `pc` and the stored loop state, so the sequencer can use them in the same cycle to select its next address.

Loops nest up to `DEPTH` levels (four by default). Start addresses, end addresses and counts sit in three separate stacks. One shared depth pointer moves all three together.

Top module: `loop_nest_ctrl`

## Requirements
- R1: After reset, `nest_depth` is 0, `ovf_err` is 0, and `branch_back` and `loop_done` are both low.
- R2: A `loop_start` pulse that is accepted pushes one entry: start = `pc`, end = `loop_end_addr`, count = `loop_count`. `nest_depth` rises by one on the next cycle.
- R3: In a cycle where `pc` equals the innermost loop's end address and that loop's count is nonzero, `branch_back` is high in the same cycle and `branch_addr` equals that loop's start address.
- R4: Each branch-back lowers the stored count by one. A loop loaded with count C therefore runs its body C+1 times.
- R5: In a cycle where `pc` equals the innermost end address and the count is zero, `loop_done` is high and the entry is popped. That level requests no branch-back.
- R6: A loop loaded with count 0 runs its body exactly once.
- R7: Up to four loops nest. When an inner loop finishes, its enclosing loop becomes the one that is checked again.
- R8: If a finishing inner loop shares its end address with the enclosing loop, the enclosing loop is evaluated in the same cycle after the pop. It may branch back, or it may finish and pop as well.
- R9: A `loop_start` while four loops are active, with no pop in that cycle, pushes nothing. `nest_depth` stays 4 and `ovf_err` becomes 1. `ovf_err` stays set until reset.
- R10: With no loop active, or with `pc` off the active end address, `branch_back` and `loop_done` stay low.
- R11: When `loop_start` coincides with an end-of-loop pop, the pop is applied first and the new loop is pushed on the reduced stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loop_start | input | 1 | Loop instruction is executing this cycle |
| loop_end_addr | input | AW (8) | Address of the last body instruction |
| loop_count | input | CW (8) | Iterations minus one |
| pc | input | AW (8) | Program counter value compared every cycle |
| branch_back | output | 1 | Fetch the loop start next instead of the sequential address |
| branch_addr | output | AW (8) | Start address to branch to |
| loop_done | output | 1 | End instruction reached with count zero |
| nest_depth | output | clog2(DEPTH+1) (3) | Number of active loops |
| ovf_err | output | 1 | Sticky nesting-overflow error |

## Verification
The bench models a sequencer with a small program of loop instructions. It counts how many times each body address is visited, which exposes off-by-one count handling: a design that decrements before testing for zero, or that treats count 0 as "skip", runs the body the wrong number of times. Nested loops that share an end address check that the enclosing loop is evaluated after the pop in the same cycle. A design that skips this would fall out of the outer loop early or repeat the inner one. A loop instruction placed so that it coincides with an outer loop's end checks pop-before-push ordering; getting it wrong leaves a stale entry on the stack. A fifth nested loop checks that the overflow error is sticky and that the stack is left undisturbed.

// File: rtl/loop_nest_pkg.sv
package loop_nest_pkg;

    // Index width for a structure of n entries, never below one bit.
    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/loop_lifo.sv
module loop_lifo
    import loop_nest_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = idx_bits(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wa_en,
    input  logic [PW-1:0]      wa_idx,
    input  logic [W-1:0]       wa_data,
    input  logic               wb_en,
    input  logic [PW-1:0]      wb_idx,
    input  logic [W-1:0]       wb_data,
    output logic [DEPTH*W-1:0] ent_o
);

    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    // Two write ports: callers never hit the same slot in one cycle.
    always_comb begin
        mem_d = mem_q;
        if (wa_en) mem_d[wa_idx] = wa_data;
        if (wb_en) mem_d[wb_idx] = wb_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign ent_o[g*W +: W] = mem_q[g];
    end

endmodule

// File: rtl/loop_end_scan.sv
module loop_end_scan
    import loop_nest_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CW    = 8,
    parameter int DEPTH = 4,
    localparam int PW   = idx_bits(DEPTH),
    localparam int SPW  = idx_bits(DEPTH + 1)
) (
    input  logic [SPW-1:0]      sp,
    input  logic [DEPTH*AW-1:0] ends_flat,
    input  logic [DEPTH*CW-1:0] cnts_flat,
    input  logic [AW-1:0]       pc,
    output logic [SPW-1:0]      pops,
    output logic                hit,
    output logic [PW-1:0]       hit_idx
);

    logic [AW-1:0] end_a [DEPTH];
    logic [CW-1:0] cnt_a [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign end_a[g] = ends_flat[g*AW +: AW];
        assign cnt_a[g] = cnts_flat[g*CW +: CW];
    end

    // Walk from the innermost level outward. Each finished level pops,
    // and the walk stops at the first level that branches or does not match.
    always_comb begin
        logic live;
        live    = 1'b1;
        pops    = '0;
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (live && (SPW'(i) < sp)) begin
                if (end_a[i] == pc) begin
                    if (cnt_a[i] == '0) begin
                        pops = pops + SPW'(1);
                    end else begin
                        hit     = 1'b1;
                        hit_idx = PW'(i);
                        live    = 1'b0;
                    end
                end else begin
                    live = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/loop_nest_ctrl.sv
module loop_nest_ctrl
    import loop_nest_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CW    = 8,
    parameter int DEPTH = 4,
    localparam int SPW  = idx_bits(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           loop_start,
    input  logic [AW-1:0]  loop_end_addr,
    input  logic [CW-1:0]  loop_count,
    input  logic [AW-1:0]  pc,
    output logic           branch_back,
    output logic [AW-1:0]  branch_addr,
    output logic           loop_done,
    output logic [SPW-1:0] nest_depth,
    output logic           ovf_err
);

    localparam int PW = idx_bits(DEPTH);

    typedef struct packed {
        logic [SPW-1:0] sp;
        logic           ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DEPTH*AW-1:0] st_flat, en_flat;
    logic [DEPTH*CW-1:0] ct_flat;
    logic [AW-1:0]       st_arr [DEPTH];
    logic [CW-1:0]       ct_arr [DEPTH];

    logic [SPW-1:0] pops, sp_after;
    logic           hit, push_ok;
    logic [PW-1:0]  hit_idx, push_idx;
    logic [CW-1:0]  hit_cnt, dec_val, top_cnt;

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign st_arr[g] = st_flat[g*AW +: AW];
        assign ct_arr[g] = ct_flat[g*CW +: CW];
    end

    loop_end_scan #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_scan (
        .sp        (ctl_q.sp),
        .ends_flat (en_flat),
        .cnts_flat (ct_flat),
        .pc        (pc),
        .pops      (pops),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    always_comb begin
        sp_after = ctl_q.sp - pops;
        push_ok  = loop_start && (sp_after != SPW'(DEPTH));
        push_idx = PW'(sp_after);
        hit_cnt  = ct_arr[hit_idx];
        dec_val  = hit_cnt - CW'(1);
        top_cnt  = (ctl_q.sp != '0) ? ct_arr[PW'(ctl_q.sp - SPW'(1))] : '0;
        ctl_d    = ctl_q;
        ctl_d.sp = push_ok ? sp_after + SPW'(1) : sp_after;
        if (loop_start && !push_ok) ctl_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    loop_lifo #(.W(AW), .DEPTH(DEPTH)) u_start_stk (
        .clk (clk), .rst_n (rst_n),
        .wa_en (1'b0), .wa_idx ('0), .wa_data ('0),
        .wb_en (push_ok), .wb_idx (push_idx), .wb_data (pc),
        .ent_o (st_flat)
    );

    loop_lifo #(.W(AW), .DEPTH(DEPTH)) u_end_stk (
        .clk (clk), .rst_n (rst_n),
        .wa_en (1'b0), .wa_idx ('0), .wa_data ('0),
        .wb_en (push_ok), .wb_idx (push_idx), .wb_data (loop_end_addr),
        .ent_o (en_flat)
    );

    loop_lifo #(.W(CW), .DEPTH(DEPTH)) u_cnt_stk (
        .clk (clk), .rst_n (rst_n),
        .wa_en (hit), .wa_idx (hit_idx), .wa_data (dec_val),
        .wb_en (push_ok), .wb_idx (push_idx), .wb_data (loop_count),
        .ent_o (ct_flat)
    );

    assign branch_back = hit;
    assign branch_addr = st_arr[hit_idx];
    assign loop_done   = (pops != '0);
    assign nest_depth  = ctl_q.sp;
    assign ovf_err     = ctl_q.ovf;

    // R2
    push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_start && !loop_done && nest_depth < SPW'(DEPTH))
        |=> nest_depth == $past(nest_depth) + SPW'(1));

    // R4
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_back && !loop_start) |=> top_cnt == $past(hit_cnt) - CW'(1));

    // R5
    done_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_done && !loop_start) |=> nest_depth < $past(nest_depth));

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nest_depth <= SPW'(DEPTH));

    // R9
    ovf_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_start && !loop_done && nest_depth == SPW'(DEPTH))
        |=> ovf_err && nest_depth == SPW'(DEPTH));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R10
    branch_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_back || loop_done) |-> nest_depth != '0);

endmodule

// File: tb/loop_nest_ctrl_tb.sv
module loop_nest_ctrl_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loop_start = 1'b0;
    logic [7:0] loop_end_addr = '0;
    logic [7:0] loop_count = '0;
    logic [7:0] pc = '0;
    logic       branch_back, loop_done, ovf_err;
    logic [7:0] branch_addr;
    logic [2:0] nest_depth;

    always #(CLK_P/2) clk = ~clk;

    loop_nest_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .loop_start (loop_start),
        .loop_end_addr (loop_end_addr), .loop_count (loop_count), .pc (pc),
        .branch_back (branch_back), .branch_addr (branch_addr),
        .loop_done (loop_done), .nest_depth (nest_depth), .ovf_err (ovf_err)
    );

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic       bb;
        logic [7:0] ba;
        logic       dn;
        logic [2:0] dp;
        logic       ov;
    } exp_t;
    exp_t exp_q[$];

    // Reference stack state, kept from the requirements
    logic [7:0] m_st [4];
    logic [7:0] m_en [4];
    logic [7:0] m_ct [4];
    int         m_sp = 0;
    logic       m_ovf = 1'b0;

    // Program image
    logic       p_loop [256];
    logic [7:0] p_end  [256];
    logic [7:0] p_cnt  [256];
    int         visits [256];

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: compare each expected item away from the clock edges
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(branch_back == e.bb, "R3 branch_back", int'(branch_back), int'(e.bb));
                if (e.bb) chk(branch_addr == e.ba, "R3 branch_addr", int'(branch_addr), int'(e.ba));
                chk(loop_done == e.dn, "R5 loop_done", int'(loop_done), int'(e.dn));
                chk(nest_depth == e.dp, "R2 nest_depth", int'(nest_depth), int'(e.dp));
                chk(ovf_err == e.ov, "R9 ovf_err", int'(ovf_err), int'(e.ov));
            end
        end
    end

    // Driver: one cycle of stimulus plus expected response
    task automatic step(input logic ls, input logic [7:0] ea, input logic [7:0] cn,
                        input logic [7:0] pcv, output logic ebb, output logic [7:0] eba);
        int   np;
        logic live;
        exp_t e;
        @(negedge clk);
        loop_start = ls; loop_end_addr = ea; loop_count = cn; pc = pcv;
        np = 0; live = 1'b1; ebb = 1'b0; eba = '0;
        e.dp = 3'(m_sp);
        e.ov = m_ovf;
        for (int i = m_sp - 1; i >= 0; i--) begin
            if (live) begin
                if (m_en[i] == pcv) begin
                    if (m_ct[i] == 0) np++;
                    else begin
                        ebb = 1'b1; eba = m_st[i]; m_ct[i] = m_ct[i] - 8'd1; live = 1'b0;
                    end
                end else live = 1'b0;
            end
        end
        m_sp = m_sp - np;
        if (ls) begin
            if (m_sp == 4) m_ovf = 1'b1;
            else begin
                m_st[m_sp] = pcv; m_en[m_sp] = ea; m_ct[m_sp] = cn; m_sp++;
            end
        end
        e.bb = ebb; e.ba = eba; e.dn = (np > 0);
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        logic bb; logic [7:0] ba;
        for (int i = 0; i < n; i++) step(1'b0, 8'd0, 8'd0, 8'd255, bb, ba);
    endtask

    task automatic clr_prog();
        for (int i = 0; i < 256; i++) begin
            p_loop[i] = 1'b0; p_end[i] = '0; p_cnt[i] = '0; visits[i] = 0;
        end
    endtask

    task automatic put_loop(input int a, input int ea, input int cn);
        p_loop[a] = 1'b1; p_end[a] = 8'(ea); p_cnt[a] = 8'(cn);
    endtask

    // Sequencer: follows the expected redirect, as the real sequencer would
    task automatic run(input int from, input int stop);
        int a; int guard;
        logic bb; logic [7:0] ba;
        a = from; guard = 0;
        while (a != stop && guard < 2000) begin
            visits[a]++;
            if (p_loop[a]) step(1'b1, p_end[a], p_cnt[a], 8'(a + 1), bb, ba);
            else           step(1'b0, 8'd0, 8'd0, 8'(a), bb, ba);
            a = bb ? int'(ba) : a + 1;
            guard++;
        end
        chk(guard < 2000, "R7 sequence terminates", guard, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        loop_start = 1'b0; pc = 8'd255;
        repeat (2) @(negedge clk);
        m_sp = 0; m_ovf = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic bb; logic [7:0] ba;
        do_reset();
        #1;
        // R1
        chk(nest_depth == 0, "R1 depth", int'(nest_depth), 0);
        chk(ovf_err == 0, "R1 ovf", int'(ovf_err), 0);
        chk(branch_back == 0 && loop_done == 0, "R1 flags", int'(branch_back), 0);

        // R10: idle with nothing active, pc on arbitrary values
        step(1'b0, 8'd0, 8'd0, 8'd0, bb, ba);
        #1; chk(!branch_back && !loop_done, "R10 idle no flags", int'(branch_back), 0);

        // R4: count 2 -> body three times
        clr_prog(); put_loop(80, 84, 2); run(80, 85);
        chk(visits[81] == 3, "R4 body passes", visits[81], 3);
        chk(visits[84] == 3, "R4 end passes", visits[84], 3);
        idle(1);

        // R10: former end address with stack empty
        step(1'b0, 8'd0, 8'd0, 8'd84, bb, ba);
        #1; chk(!branch_back && !loop_done, "R10 stale end", int'(loop_done), 0);

        // R6: count 0 -> body once
        clr_prog(); put_loop(90, 92, 0); run(90, 93);
        chk(visits[91] == 1, "R6 single pass", visits[91], 1);
        idle(1);

        // R7: two levels with distinct ends
        clr_prog(); put_loop(10, 20, 1); put_loop(12, 15, 2); run(10, 21);
        chk(visits[13] == 6, "R7 inner passes", visits[13], 6);
        chk(visits[16] == 2, "R7 outer passes", visits[16], 2);
        idle(1);
        #1; chk(nest_depth == 0, "R7 depth unwound", int'(nest_depth), 0);

        // R8: shared end address
        clr_prog(); put_loop(30, 40, 1); put_loop(34, 40, 1); run(30, 41);
        chk(visits[35] == 4, "R8 inner passes", visits[35], 4);
        chk(visits[31] == 2, "R8 outer passes", visits[31], 2);
        idle(1);
        #1; chk(nest_depth == 0, "R8 depth unwound", int'(nest_depth), 0);

        // R11: loop instruction lands on the outer end
        clr_prog(); put_loop(100, 105, 0); put_loop(104, 110, 0); run(100, 111);
        chk(visits[105] == 1, "R11 new loop start", visits[105], 1);
        chk(visits[101] == 1, "R11 outer once", visits[101], 1);
        idle(1);
        #1; chk(nest_depth == 0, "R11 depth unwound", int'(nest_depth), 0);

        // R9: fifth nested loop
        clr_prog();
        put_loop(40, 60, 0); put_loop(41, 59, 0); put_loop(42, 58, 0);
        put_loop(43, 57, 0); put_loop(44, 56, 0);
        run(40, 61);
        idle(3);
        #1; chk(ovf_err == 1, "R9 sticky ovf", int'(ovf_err), 1);
        chk(visits[45] == 1, "R9 body once", visits[45], 1);
        do_reset();
        #1; chk(ovf_err == 0, "R9 reset clears", int'(ovf_err), 0);
        idle(2);

        @(negedge clk);
        #(CLK_P/2);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule